// File: doc/BRIEF.md
# Reshapable Two-Port RAM

This block is a memory of 1,152 bits with one write port and one read port, each clocked on its own. A two-bit shape input sets how the bits are grouped into words: 64 words of 18 bits, 128 words of 9 bits, 256 words of 4 bits, or 512 words of 2 bits. Both address buses are 9 bits wide and both data buses are 18 bits wide. Each shape uses only the low-order lines it needs.

Writes take effect on a rising write-clock edge when the write enable is high. The read port has two styles, chosen by a read-style input. In the registered style, the read enable acts as a clock enable on an output register. In the flow-through style, the output follows the addressed word while the read enable is high. When the read enable goes low, the output holds the word most recently captured.

The bits are stored as one linear array. A word's bit position depends only on its address and its width. After the shape changes, the existing contents are read back reinterpreted rather than lost.

Top module: `ratio_ram`

## Requirements
- R1: The `mode` input selects the shape: 0 gives 64x18, 1 gives 128x9, 2 gives 256x4 and 3 gives 512x2. A word written in a shape and read back in the same shape returns its low N data bits, where N is the width of that shape.
- R2: In an N-bit shape, the word at address A occupies linear array bits A*N through A*N+N-1. Reading in a different shape returns those same stored bits, regrouped.
- R3: Address bits above the range of the current shape are ignored on both ports. That range is [5:0], [6:0], [7:0] or [8:0] for modes 0 to 3.
- R4: Write-data bits at position N and above are not stored. Read-data bits at position N and above are driven to zero.
- R5: The array changes only on a rising `wclk` edge with `we` high. With `we` low, the contents stay as they were.
- R6: When `asyncRd` is low, `rd` updates on a rising `rclk` edge where `re` is high, and holds its value across edges where `re` is low.
- R7: When `asyncRd` and `re` are both high, `rd` follows the addressed word combinationally, with no clock edge needed.
- R8: When `asyncRd` is high and `re` is low, `rd` shows the word captured at the last rising `rclk` edge where `re` was high.
- R9: When `wclk` and `rclk` are the same clock, a registered read and a write to the same address on the same edge return the old data.
- R10: While `rstN` is low, the read register is cleared, so a registered read shows zero.
- R11: The write and read ports run on unrelated clock frequencies. Data written on `wclk` is returned by a later read on `rclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Shape select (0: 64x18, 1: 128x9, 2: 256x4, 3: 512x2) |
| rstN | input | 1 | Active-low asynchronous clear of the read register |
| wclk | input | 1 | Write port clock |
| we | input | 1 | Write enable, a clock enable on `wclk` |
| waddr | input | 9 | Write word address |
| wdata | input | 18 | Write data, low N bits used |
| rclk | input | 1 | Read port clock |
| re | input | 1 | Read enable |
| raddr | input | 9 | Read word address |
| asyncRd | input | 1 | Read style: 0 registered, 1 flow-through |
| rd | output | 18 | Read data, bits N and above are zero |

## Verification
The bench builds the block with the default package values: an 18-bit maximum width and a 6-bit base address, giving 1,152 bits. With these values, the last word of the 18-bit shape (bits 1134 to 1151) can be reached. The 4-bit shape is also covered, and because 18 is not a multiple of 4, one of its words straddles two 18-bit rows. These values also let cross-shape reads show the same bits regrouped. Running the two clocks at 8 ns and 11 ns exercises independent timing, and a temporary shared clock reaches the same-edge collision case.

// File: rtl/ratio_ram_pkg.sv
package ratio_ram_pkg;
  localparam int MAX_W  = 18;
  localparam int MIN_AW = 6;
  localparam int ADDR_W = MIN_AW + 3;
  localparam int BITS   = MAX_W * (1 << MIN_AW);
  localparam int BIT_AW = $clog2(BITS);

  typedef enum logic [1:0] {
    SHAPE_X18 = 2'd0,
    SHAPE_X9  = 2'd1,
    SHAPE_X4  = 2'd2,
    SHAPE_X2  = 2'd3
  } shape_e;

  typedef struct packed {
    logic              en;
    logic [BIT_AW-1:0] base;
    logic [MAX_W-1:0]  mask;
  } wr_strobe_t;

  typedef struct packed {
    logic              capture;
    logic              flow;
    logic [BIT_AW-1:0] base;
    logic [MAX_W-1:0]  mask;
  } rd_strobe_t;

  function automatic int shapeWidth(input shape_e s);
    return MAX_W >> int'(s);
  endfunction

  function automatic int shapeAddrMask(input shape_e s);
    return (1 << (MIN_AW + int'(s))) - 1;
  endfunction
endpackage

// File: rtl/ratio_ram_ctrl.sv
module ratio_ram_ctrl
  import ratio_ram_pkg::*;
(
  input  shape_e            shape,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              asyncRd,
  output wr_strobe_t        wStr,
  output rd_strobe_t        rStr
);
  logic [ADDR_W-1:0] addrMask;
  logic [ADDR_W-1:0] waUsed;
  logic [ADDR_W-1:0] raUsed;
  logic [MAX_W-1:0]  wordMask;
  int                width;

  always_comb begin
    width    = shapeWidth(shape);
    addrMask = ADDR_W'(shapeAddrMask(shape));
    wordMask = MAX_W'((1 << width) - 1);
    waUsed   = waddr & addrMask;
    raUsed   = raddr & addrMask;

    wStr.en   = we;
    wStr.base = BIT_AW'(int'(waUsed) * width);
    wStr.mask = wordMask;

    rStr.capture = re;
    rStr.flow    = asyncRd & re;
    rStr.base    = BIT_AW'(int'(raUsed) * width);
    rStr.mask    = wordMask;
  end
endmodule

// File: rtl/ratio_ram_array.sv
module ratio_ram_array
  import ratio_ram_pkg::*;
(
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rstN,
  input  wr_strobe_t       wStr,
  input  rd_strobe_t       rStr,
  input  logic [MAX_W-1:0] wdata,
  output logic [MAX_W-1:0] rd
);
  logic [BITS-1:0]  mem;
  logic [BITS-1:0]  wMaskWide;
  logic [BITS-1:0]  wDataWide;
  logic [MAX_W-1:0] liveWord;
  logic [MAX_W-1:0] rdReg;

  assign wMaskWide = {{(BITS-MAX_W){1'b0}}, wStr.mask} << wStr.base;
  assign wDataWide = {{(BITS-MAX_W){1'b0}}, wdata} << wStr.base;

  always_ff @(posedge wclk) begin
    if (wStr.en) mem <= (mem & ~wMaskWide) | (wDataWide & wMaskWide);
  end

  assign liveWord = MAX_W'(mem >> rStr.base) & rStr.mask;

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)             rdReg <= '0;
    else if (rStr.capture) rdReg <= liveWord;
  end

  assign rd = rStr.flow ? liveWord : (rdReg & rStr.mask);

  // R5: no write enable, no change in storage
  a_r5_write_gated: assert property (@(posedge wclk) disable iff (!rstN)
    !wStr.en |=> $stable(mem));

  // R2: a written word stays inside the physical array
  a_r2_base_in_range: assert property (@(posedge wclk) disable iff (!rstN)
    wStr.en |-> (int'(wStr.base) + $countones(wStr.mask) <= BITS));

  // R6: read register holds without read enable
  a_r6_read_hold: assert property (@(posedge rclk) disable iff (!rstN)
    !rStr.capture |=> $stable(rdReg));
endmodule

// File: rtl/ratio_ram.sv
module ratio_ram
  import ratio_ram_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              rstN,
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [MAX_W-1:0]  wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              asyncRd,
  output logic [MAX_W-1:0]  rd
);
  wr_strobe_t wStr;
  rd_strobe_t rStr;

  ratio_ram_ctrl u_ctrl (
    .shape   (shape_e'(mode)),
    .we      (we),
    .waddr   (waddr),
    .re      (re),
    .raddr   (raddr),
    .asyncRd (asyncRd),
    .wStr    (wStr),
    .rStr    (rStr)
  );

  ratio_ram_array u_array (
    .wclk  (wclk),
    .rclk  (rclk),
    .rstN  (rstN),
    .wStr  (wStr),
    .rStr  (rStr),
    .wdata (wdata),
    .rd    (rd)
  );

  // R4: read bits at and above the shape width are zero
  a_r4_upper_zero: assert property (@(posedge rclk) disable iff (!rstN)
    (32'(rd) >> shapeWidth(shape_e'(mode))) == 0);
endmodule

// File: tb/tb_ratio_ram.sv
`timescale 1ns/100ps
module tb_ratio_ram;
  logic [1:0]  mode = 2'd0;
  logic        rstN = 1'b0;
  logic        wclk = 1'b0;
  logic        rclkFree = 1'b0;
  logic        shareClk = 1'b0;
  logic        rclk;
  logic        we = 1'b0;
  logic [8:0]  waddr = '0;
  logic [17:0] wdata = '0;
  logic        re = 1'b0;
  logic [8:0]  raddr = '0;
  logic        asyncRd = 1'b0;
  logic [17:0] rd;
  int          vectors = 0;
  int          miss = 0;
  bit          done = 0;

  always #4 wclk = ~wclk;
  always #5.5 rclkFree = ~rclkFree;
  assign rclk = shareClk ? wclk : rclkFree;

  ratio_ram dut (
    .mode(mode), .rstN(rstN), .wclk(wclk), .we(we), .waddr(waddr),
    .wdata(wdata), .rclk(rclk), .re(re), .raddr(raddr),
    .asyncRd(asyncRd), .rd(rd)
  );

  // {mode, waddr, wdata, raddr, expected}
  localparam logic [55:0] VEC [9] = '{
    {2'd0, 9'h005, 18'h3ABCD, 9'h005, 18'h3ABCD},
    {2'd0, 9'h1C5, 18'h12345, 9'h005, 18'h12345},
    {2'd1, 9'h07F, 18'h3FFFF, 9'h07F, 18'h001FF},
    {2'd1, 9'h000, 18'h000AA, 9'h100, 18'h000AA},
    {2'd2, 9'h0FF, 18'h0000B, 9'h0FF, 18'h0000B},
    {2'd2, 9'h010, 18'h3FFF5, 9'h110, 18'h00005},
    {2'd3, 9'h1FF, 18'h00003, 9'h1FF, 18'h00003},
    {2'd3, 9'h002, 18'h3FFFE, 9'h002, 18'h00002},
    {2'd0, 9'h03F, 18'h20001, 9'h1FF, 18'h20001}
  };

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [8:0] a, input logic [17:0] d);
    @(posedge wclk); #1;
    mode = m; waddr = a; wdata = d; we = 1'b1;
    @(posedge wclk); #1;
    we = 1'b0;
  endtask

  task automatic readSync(input logic [1:0] m, input logic [8:0] a);
    @(posedge rclk); #1;
    mode = m; raddr = a; re = 1'b1;
    @(posedge rclk); #1;
    re = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
  endtask

  initial begin
    #100000;
    if (!done) begin
      vectors++; miss++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge wclk);
    #1 check("R10 reset clears read", rd, 18'h0);
    @(posedge rclk); #1 rstN = 1'b1;

    // R1 R3 R4 R11: table walk, writes on wclk and reads on rclk
    foreach (VEC[i]) begin
      doWrite(VEC[i][55:54], VEC[i][53:45], VEC[i][44:27]);
      readSync(VEC[i][55:54], VEC[i][26:18]);
      check($sformatf("R1 R3 R4 R11 vector %0d", i), rd, VEC[i][17:0]);
    end

    // R2 reinterpretation across shapes
    doWrite(2'd0, 9'h000, 18'h2D36B);
    readSync(2'd3, 9'h000); check("R2 x2 word0", rd, 18'h00003);
    readSync(2'd3, 9'h001); check("R2 x2 word1", rd, 18'h00002);
    readSync(2'd1, 9'h000); check("R2 x9 word0", rd, 18'h0016B);
    readSync(2'd1, 9'h001); check("R2 x9 word1", rd, 18'h00169);
    readSync(2'd2, 9'h001); check("R2 x4 word1", rd, 18'h00006);
    doWrite(2'd2, 9'h004, 18'h0000F);
    readSync(2'd0, 9'h000); check("R2 x4 straddle row0", rd, 18'h3D36B);
    readSync(2'd3, 9'h009); check("R2 x4 straddle row1", rd, 18'h00003);

    // R5 write with enable low
    @(posedge wclk); #1;
    mode = 2'd0; waddr = 9'h000; wdata = 18'h00000; we = 1'b0;
    repeat (2) @(posedge wclk);
    readSync(2'd0, 9'h000); check("R5 no write without we", rd, 18'h3D36B);

    // R6 registered read holds with re low
    doWrite(2'd0, 9'h002, 18'h0F0F0);
    readSync(2'd0, 9'h000);
    raddr = 9'h002;
    repeat (2) @(posedge rclk);
    #1 check("R6 hold with re low", rd, 18'h3D36B);
    readSync(2'd0, 9'h002); check("R6 load with re high", rd, 18'h0F0F0);

    // R7 R8 flow-through
    asyncRd = 1'b1;
    @(posedge rclk); #1;
    raddr = 9'h000; re = 1'b1;
    #1 check("R7 flow word0", rd, 18'h3D36B);
    @(posedge rclk); #1;
    raddr = 9'h002;
    #1 check("R7 flow word2", rd, 18'h0F0F0);
    re = 1'b0;
    #1 check("R8 hold after re low", rd, 18'h3D36B);
    repeat (2) @(posedge rclk);
    #1 check("R8 hold across edges", rd, 18'h3D36B);
    asyncRd = 1'b0;

    // R9 same-address collision on a shared clock
    doWrite(2'd0, 9'h007, 18'h11111);
    shareClk = 1'b1;
    @(posedge wclk); #1;
    waddr = 9'h007; wdata = 18'h22222; we = 1'b1;
    raddr = 9'h007; re = 1'b1;
    @(posedge wclk); #1;
    we = 1'b0; re = 1'b0;
    check("R9 collision returns old", rd, 18'h11111);
    readSync(2'd0, 9'h007); check("R9 new data after", rd, 18'h22222);
    shareClk = 1'b0;

    // R10 reset mid-run
    #2 rstN = 1'b0;
    #1 check("R10 mid-run reset", rd, 18'h0);
    @(posedge rclk); #1 rstN = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule